// File: doc/BRIEF.md
# Flash Erase Block Selector

This block holds the erase-area choice for a small on-chip flash array. Software writes an 8-bit register whose low five bits are one-hot, one bit for each erase block. The block compares the address presented on its flash-address input against a fixed map of blocks. It raises an erase-permit output only when that address falls inside the block that is currently selected. Every other block stays protected.

The register only keeps a value while the software-write-enable input is high. When that input drops, the select field clears. A write that sets two or more select bits also clears the field instead of storing it. The only way to erase the whole array is therefore to select and erase one block after another. Four 1 KB blocks sit at the bottom of the address space. A fifth block starts at 0x1000, and the `LARGE_MAP` parameter sets where it ends.

Top module: `erase_sel`

## Requirements
- R1: `reg_rdata` bits 7 to 5 always read 0, and write data in those bits has no effect.
- R2: After reset, `reg_rdata` is 0x00 and `erase_ok` is 0.
- R3: While `sw_en` is low, `reg_rdata` reads 0x00 and `erase_ok` is 0. Each clock edge with `sw_en` low clears the select field, so it is still 0x00 when `sw_en` rises again.
- R4: A write with `reg_we` high while `sw_en` is low is ignored.
- R5: With `sw_en` high, a write whose bits 4..0 hold at most one 1 stores those bits. The new value replaces the previous selection.
- R6: With `sw_en` high, a write whose bits 4..0 hold two or more 1s sets the field to 0x00.
- R7: Select bit k, for k from 0 to 3, permits exactly the addresses k*0x400 through k*0x400+0x3FF.
- R8: Select bit 4 permits the addresses 0x1000 through the top of the array. The top is 0x3FFF when `LARGE_MAP`=0 and 0x7FFF when `LARGE_MAP`=1.
- R9: An address above the top of the array never produces a permit.
- R10: With the field at 0x00, `erase_ok` is 0 for every address.
- R11: `erase_ok` is combinational from the stored field and `flash_addr`. It reflects a write in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Software write enable; low clears and holds the field |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| flash_addr | input | ADDR_W | Flash address to check |
| erase_ok | output | 1 | Erase permitted for `flash_addr` |

## Verification
The hardest situation to create is a field that was cleared by `sw_en` going low and then stays empty after the enable comes back. Reading the register while `sw_en` is low only shows the gated output, not the stored state. To reach it, the stimulus first stores a valid selection, then drops `sw_en` for a cycle while also writing. It then raises `sw_en` with no write and reads the register and the permit. The multi-bit clear is reached by writing over an existing valid selection, so a design that kept the old value fails the check.

// File: rtl/erase_sel.sv
module erase_sel #(
  parameter int ADDR_W    = 16,
  parameter bit LARGE_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] flash_addr,
  output logic              erase_ok
);

  localparam int NBLK    = 5;
  localparam int SMALL_W = 10;
  localparam int SMALL_N = 4;
  localparam logic [ADDR_W-1:0] BIG_BASE = ADDR_W'(SMALL_N << SMALL_W);
  localparam logic [ADDR_W-1:0] TOP_ADDR = LARGE_MAP ? ADDR_W'(16'h7FFF) : ADDR_W'(16'h3FFF);

  logic [NBLK-1:0] sel_q;
  logic [NBLK-1:0] hit;
  logic            multi;

  assign multi = $countones(reg_wdata[NBLK-1:0]) > 1;

  always_ff @(posedge clk) begin
    if (!rst_n || !sw_en)
      sel_q <= '0;
    else if (reg_we)
      sel_q <= multi ? '0 : reg_wdata[NBLK-1:0];
  end

  genvar k;
  generate
    for (k = 0; k < SMALL_N; k++) begin : g_small
      assign hit[k] = (flash_addr >= ADDR_W'(k << SMALL_W)) &&
                      (flash_addr <  ADDR_W'((k + 1) << SMALL_W));
    end
  endgenerate

  assign hit[NBLK-1] = (flash_addr >= BIG_BASE) && (flash_addr <= TOP_ADDR);

  assign reg_rdata = sw_en ? {{(8-NBLK){1'b0}}, sel_q} : 8'h00;
  assign erase_ok  = sw_en && |(sel_q & hit);

endmodule

// File: rtl/erase_sel_chk.sv
module erase_sel_chk #(
  parameter int ADDR_W    = 16,
  parameter bit LARGE_MAP = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_en,
  input logic              reg_we,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              erase_ok
);

  localparam logic [ADDR_W-1:0] TOP = LARGE_MAP ? ADDR_W'(16'h7FFF) : ADDR_W'(16'h3FFF);

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:5] == 3'b000);

  // R3
  reenable_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !$past(sw_en)) |-> reg_rdata == 8'h00);

  // R5
  single_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && reg_we && $countones(reg_wdata[4:0]) <= 1) |=>
      (!sw_en || reg_rdata[4:0] == $past(reg_wdata[4:0])));

  // R6
  multi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && reg_we && $countones(reg_wdata[4:0]) > 1) |=> reg_rdata == 8'h00);

  // R9
  above_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_addr > TOP) |-> !erase_ok);

  // R10
  empty_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata == 8'h00) |-> !erase_ok);

  // R5
  onehot_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_rdata));

endmodule

bind erase_sel erase_sel_chk #(.ADDR_W(ADDR_W), .LARGE_MAP(LARGE_MAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .flash_addr(flash_addr), .erase_ok(erase_ok)
);

// File: tb/sim_erase_sel.sv
module sim_erase_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [15:0] flash_addr = 16'h0000;
  logic        erase_ok;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  erase_sel #(.ADDR_W(16), .LARGE_MAP(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flash_addr(flash_addr), .erase_ok(erase_ok)
  );

  // {wdata, addr, expected rdata, expected permit}
  localparam int NV = 20;
  localparam logic [32:0] VEC [NV] = '{
    {8'h01, 16'h0000, 8'h01, 1'b1}, // R7
    {8'h01, 16'h03FF, 8'h01, 1'b1}, // R7
    {8'h01, 16'h0400, 8'h01, 1'b0}, // R7
    {8'h02, 16'h0400, 8'h02, 1'b1}, // R7
    {8'h02, 16'h07FF, 8'h02, 1'b1}, // R7
    {8'h04, 16'h0800, 8'h04, 1'b1}, // R7
    {8'h04, 16'h0BFF, 8'h04, 1'b1}, // R7
    {8'h08, 16'h0C00, 8'h08, 1'b1}, // R7
    {8'h08, 16'h0FFF, 8'h08, 1'b1}, // R7
    {8'h08, 16'h1000, 8'h08, 1'b0}, // R7
    {8'h10, 16'h1000, 8'h10, 1'b1}, // R8
    {8'h10, 16'h3FFF, 8'h10, 1'b1}, // R8
    {8'h10, 16'h4000, 8'h10, 1'b0}, // R9
    {8'h10, 16'hFFFF, 8'h10, 1'b0}, // R9
    {8'h03, 16'h0000, 8'h00, 1'b0}, // R6
    {8'h04, 16'h0800, 8'h04, 1'b1}, // R5
    {8'h18, 16'h1000, 8'h00, 1'b0}, // R6
    {8'hE4, 16'h0800, 8'h04, 1'b1}, // R1
    {8'h00, 16'h0800, 8'h00, 1'b0}, // R10
    {8'h1F, 16'h0000, 8'h00, 1'b0}  // R6
  };

  task automatic check(input string req, input logic [7:0] exp_rd, input logic exp_ok);
    checks++;
    if (reg_rdata !== exp_rd || erase_ok !== exp_ok) begin
      fails++;
      $display("FAIL %s: rdata=%h ok=%b expected rdata=%h ok=%b",
               req, reg_rdata, erase_ok, exp_rd, exp_ok);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; sw_en = 1'b1;
    @(negedge clk);
    check("R2", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][32:25]);
      flash_addr = VEC[i][24:9];
      #1 check("R11", VEC[i][8:1], VEC[i][0]);
    end

    // sw_en low with an active selection
    wr(8'h02); flash_addr = 16'h0500;
    #1 check("R5", 8'h02, 1'b1);
    @(negedge clk); sw_en = 1'b0;
    #1 check("R3", 8'h00, 1'b0);
    wr(8'h08);
    @(negedge clk); sw_en = 1'b1; flash_addr = 16'h0C00;
    #1 check("R4", 8'h00, 1'b0);
    flash_addr = 16'h0500;
    #1 check("R3", 8'h00, 1'b0);

    // multi-bit write over a valid selection
    wr(8'h10); flash_addr = 16'h2000;
    #1 check("R8", 8'h10, 1'b1);
    wr(8'h11);
    #1 check("R6", 8'h00, 1'b0);

    // reset clears selection
    wr(8'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; flash_addr = 16'h0000;
    #1 check("R2", 8'h00, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: ran=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule